// File: doc/BRIEF.md
# Two-Step Subranging Converter Sequencer

This block is the digital half of a two-step subranging analog-to-digital converter. It drives the strobes for the input sample-hold, for the coarse comparator bank, for the residue sample-hold and for the fine comparator bank. Each comparator bank is captured in a register before it is decoded, so unequal decoder path delays cannot reach the result. The coarse thermometer pattern becomes a binary code. That code goes to an external reconstruction DAC, whose output is subtracted from the held input to form the residue. After a programmable settling wait, the fine bank is captured and decoded. The coarse and fine codes are joined into one output word, with the coarse code in the upper field.

In pipelined mode the residue sample-hold frees the coarse stage early. The coarse bank of sample n+1 is then captured in the same cycle as the fine bank of sample n. The block keeps the coarse code of sample n so that it is paired with the fine code of the same sample. While start is low, a pending residue is finished without a new sample. Both decoders tolerate one isolated bubble in their thermometer input and flag heavier corruption. The output fields can be given in straight binary or in Gray code.

Top module: `subrng_adc_ctrl`

## Requirements
- R1: With gray_sel low, word_out holds the coarse code in bits [5:3] and the fine code in bits [2:0] (default widths). Each code is the number of the highest thermometer input that is 1, counting from 1 at bit 0, or 0 when all inputs are 0.
- R2: With gray_sel high at output time, each field is Gray coded on its own: g = b ^ (b >> 1).
- R3: In non-pipelined mode, with settle_cnt = S, a conversion runs in this order: sample_hold, coarse_latch in the next cycle, residue_hold, then fine_latch exactly 5+S cycles after sample_hold. Each strobe is high for one cycle. sample_hold, coarse_latch and residue_hold are never high together.
- R4: dac_code carries the binary coarse code from the second cycle after coarse_latch. It holds that value through residue_hold and the matching fine_latch.
- R5: A single 0 below the highest 1 of a thermometer input (a bubble) is corrected. The code is still the position of the highest 1, and word_err stays low.
- R6: word_err is high with a word when either input of that sample has two or more 0 bits below its highest 1.
- R7: With pipe_en high, fine_latch for sample n is high in the same cycle as coarse_latch for sample n+1. Each word joins the coarse and fine codes of one sample. No word is valid before the second sample_hold.
- R8: In pipelined mode, when start is low and a residue is pending, the block captures the fine bank alone and emits the last word.
- R9: word_valid is a single-cycle pulse, and there is one pulse per converted sample.
- R10: While rst_n is low at a clock edge, all strobes, word_valid, word_out and dac_code go to 0. This also applies in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| pipe_en | input | 1 | Overlap coarse and fine stages |
| gray_sel | input | 1 | Gray-coded output fields when high |
| settle_cnt | input | SETTLE_W | Extra DAC settling cycles |
| coarse_therm | input | 2^COARSE_BITS-1 | Coarse comparator outputs, bit 0 lowest threshold |
| fine_therm | input | 2^FINE_BITS-1 | Fine comparator outputs, bit 0 lowest threshold |
| sample_hold | output | 1 | Input sample-hold strobe |
| coarse_latch | output | 1 | Coarse comparator capture strobe |
| residue_hold | output | 1 | Residue sample-hold strobe |
| fine_latch | output | 1 | Fine comparator capture strobe |
| dac_code | output | COARSE_BITS | Binary code to the reconstruction DAC |
| word_out | output | COARSE_BITS+FINE_BITS | Joined conversion result |
| word_valid | output | 1 | One-cycle pulse marking a new word |
| word_err | output | 1 | Thermometer corruption seen in this word |

## Verification
The bench drives thermometer patterns that include a clean full scale, an all-zero input, single bubbles and multi-zero corruption. A decoder that took the lowest transition or counted ones would give wrong codes there, and one without the error rule would keep word_err low. Back-to-back pipelined samples with distinct codes show whether the coarse field is delayed: an unaligned design pairs the coarse code of sample n+1 with the fine code of sample n. The bench measures the distance from sample_hold to fine_latch at several settle counts, which catches off-by-one waits. It also stops a pipelined burst to confirm the flush, where a faulty design would lose the last word. A reset in mid-conversion must park the DAC code at zero at once.

// File: rtl/subrng_pkg.sv
// Shared types for the subranging converter sequencer.
// Assumes code fields no wider than 16 bits.
package subrng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CLATCH,
        ST_CDEC,
        ST_SETTLE,
        ST_RHOLD,
        ST_FLATCH,
        ST_EMIT
    } seq_state_t;

    // Reflected binary conversion of a code of up to 16 bits.
    function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/subrng_therm_dec.sv
// Thermometer-to-binary decoder with single-bubble tolerance.
// The transition is the highest input that is 1 with a 0 (or the top)
// above it. Two or more zeros below that point raise bad.
// Assumes the input has already been registered (combinational only).
module subrng_therm_dec #(
    parameter int M = 3,
    localparam int N = (1 << M) - 1
) (
    input  logic [N-1:0] therm,
    output logic [M-1:0] code,
    output logic         bad
);

    logic [N:0] ext;
    logic [M:0] pos;
    logic [M:0] ones;
    logic [M:0] holes;

    assign ext = {1'b0, therm};

    // Locate the highest 1-to-0 transition and count the ones.
    always_comb begin
        pos  = '0;
        ones = '0;
        for (int i = 0; i < N; i++) begin
            if (ext[i]) begin
                ones = ones + 1'b1;
            end
            if (ext[i] && !ext[i+1]) begin
                pos = (M+1)'(i + 1);
            end
        end
    end

    // Zeros below the transition give the error measure.
    assign holes = pos - ones;
    assign bad   = (holes > (M+1)'(1));
    assign code  = pos[M-1:0];

endmodule

// File: rtl/subrng_field_fmt.sv
// Output field formatter: passes a binary code or its Gray form.
// Assumes W <= 16.
module subrng_field_fmt #(
    parameter int W = 3
) (
    input  logic [W-1:0] bin,
    input  logic         gray_sel,
    output logic [W-1:0] fmt
);

    logic [15:0] wide;

    // Widen, convert and select the field encoding.
    always_comb begin
        wide = subrng_pkg::bin_to_gray(16'(bin));
        fmt  = gray_sel ? wide[W-1:0] : bin;
    end

endmodule

// File: rtl/subrng_seq.sv
// Conversion sequencer: walks sample, coarse capture, DAC update,
// settle wait, residue hold and fine capture. In pipelined mode the
// fine capture of a pending residue is merged into the next coarse
// capture, or done alone (flush) when no new request is present.
// Assumes start is a level request sampled only while idle.
module subrng_seq #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                pipe_en,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                sample_hold,
    output logic                coarse_latch,
    output logic                residue_hold,
    output logic                fine_latch,
    output logic                coarse_upd,
    output logic                emit
);
    import subrng_pkg::*;

    seq_state_t          state;
    logic [SETTLE_W-1:0] wait_cnt;
    logic                pend;
    logic                fine_got;

    // State, settle counter and pipeline bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            pend     <= 1'b0;
            fine_got <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start)     state <= ST_SAMPLE;
                    else if (pend) state <= ST_FLATCH;
                end
                ST_SAMPLE: state <= ST_CLATCH;
                ST_CLATCH: begin
                    fine_got <= pend;
                    pend     <= 1'b0;
                    state    <= ST_CDEC;
                end
                ST_CDEC: begin
                    wait_cnt <= settle_cnt;
                    fine_got <= 1'b0;
                    state    <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (wait_cnt == '0) state <= ST_RHOLD;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                ST_RHOLD: begin
                    if (pipe_en) begin
                        pend  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_FLATCH;
                    end
                end
                ST_FLATCH: begin
                    pend  <= 1'b0;
                    state <= ST_EMIT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes and datapath enables decoded from the state.
    always_comb begin
        sample_hold  = (state == ST_SAMPLE);
        coarse_latch = (state == ST_CLATCH);
        residue_hold = (state == ST_RHOLD);
        fine_latch   = (state == ST_FLATCH) || ((state == ST_CLATCH) && pend);
        coarse_upd   = (state == ST_CDEC);
        emit         = ((state == ST_CDEC) && fine_got) || (state == ST_EMIT);
    end

    AST_SAMPLE_THEN_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |=> coarse_latch); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_hold, coarse_latch, residue_hold})); // R3
    AST_OVERLAP_ONLY_PIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_latch && fine_latch) |-> $past(pend)); // R7

endmodule

// File: rtl/subrng_adc_ctrl.sv
// Top of the subranging converter back end. Registers both comparator
// banks on their strobes, decodes them, drives the reconstruction DAC,
// keeps the coarse code until its fine partner arrives and formats the
// joined word. Assumes the comparator inputs are settled when their
// capture strobe is high.
module subrng_adc_ctrl #(
    parameter int COARSE_BITS = 3,
    parameter int FINE_BITS   = 3,
    parameter int SETTLE_W    = 8,
    localparam int C_TAPS = (1 << COARSE_BITS) - 1,
    localparam int F_TAPS = (1 << FINE_BITS) - 1,
    localparam int W_BITS = COARSE_BITS + FINE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   pipe_en,
    input  logic                   gray_sel,
    input  logic [SETTLE_W-1:0]    settle_cnt,
    input  logic [C_TAPS-1:0]      coarse_therm,
    input  logic [F_TAPS-1:0]      fine_therm,
    output logic                   sample_hold,
    output logic                   coarse_latch,
    output logic                   residue_hold,
    output logic                   fine_latch,
    output logic [COARSE_BITS-1:0] dac_code,
    output logic [W_BITS-1:0]      word_out,
    output logic                   word_valid,
    output logic                   word_err
);

    logic                   coarse_upd;
    logic                   emit;
    logic [C_TAPS-1:0]      coarse_q;
    logic [F_TAPS-1:0]      fine_q;
    logic [COARSE_BITS-1:0] c_code;
    logic [FINE_BITS-1:0]   f_code;
    logic                   c_bad;
    logic                   f_bad;
    logic [COARSE_BITS-1:0] held_code;
    logic                   held_bad;
    logic [COARSE_BITS-1:0] c_fmt;
    logic [FINE_BITS-1:0]   f_fmt;

    subrng_seq #(.SETTLE_W(SETTLE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pipe_en      (pipe_en),
        .settle_cnt   (settle_cnt),
        .sample_hold  (sample_hold),
        .coarse_latch (coarse_latch),
        .residue_hold (residue_hold),
        .fine_latch   (fine_latch),
        .coarse_upd   (coarse_upd),
        .emit         (emit)
    );

    // Capture both comparator banks on their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else begin
            if (coarse_latch) coarse_q <= coarse_therm;
            if (fine_latch)   fine_q   <= fine_therm;
        end
    end

    subrng_therm_dec #(.M(COARSE_BITS)) u_cdec (
        .therm (coarse_q),
        .code  (c_code),
        .bad   (c_bad)
    );

    subrng_therm_dec #(.M(FINE_BITS)) u_fdec (
        .therm (fine_q),
        .code  (f_code),
        .bad   (f_bad)
    );

    // Drive the DAC and keep the coarse result for its fine partner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code  <= '0;
            held_code <= '0;
            held_bad  <= 1'b0;
        end else if (coarse_upd) begin
            dac_code  <= c_code;
            held_code <= c_code;
            held_bad  <= c_bad;
        end
    end

    subrng_field_fmt #(.W(COARSE_BITS)) u_cfmt (
        .bin      (held_code),
        .gray_sel (gray_sel),
        .fmt      (c_fmt)
    );

    subrng_field_fmt #(.W(FINE_BITS)) u_ffmt (
        .bin      (f_code),
        .gray_sel (gray_sel),
        .fmt      (f_fmt)
    );

    // Register the joined word and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_err   <= 1'b0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= emit;
            if (emit) begin
                word_out <= {c_fmt, f_fmt};
                word_err <= held_bad | f_bad;
            end
        end
    end

    AST_DAC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (residue_hold || (fine_latch && !coarse_latch)) |-> $stable(dac_code)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R9
    AST_RESET_PARK: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && !word_valid && !sample_hold)); // R10

endmodule

// File: tb/sim_subrng_adc_ctrl.sv
module sim_subrng_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       pipe_en;
    logic       gray_sel;
    logic [7:0] settle_cnt;
    logic [6:0] coarse_therm;
    logic [6:0] fine_therm;
    logic       sample_hold, coarse_latch, residue_hold, fine_latch;
    logic [2:0] dac_code;
    logic [5:0] word_out;
    logic       word_valid, word_err;

    always #10 clk = ~clk;

    subrng_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pipe_en(pipe_en),
        .gray_sel(gray_sel), .settle_cnt(settle_cnt),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm),
        .sample_hold(sample_hold), .coarse_latch(coarse_latch),
        .residue_hold(residue_hold), .fine_latch(fine_latch),
        .dac_code(dac_code), .word_out(word_out),
        .word_valid(word_valid), .word_err(word_err)
    );

    // {coarse therm, fine therm, expected binary word, expected error}
    localparam logic [20:0] VEC [8] = '{
        {7'b0000000, 7'b0000000, 6'o00, 1'b0},
        {7'b0000001, 7'b1111111, 6'o17, 1'b0},
        {7'b0000111, 7'b0000011, 6'o32, 1'b0},
        {7'b1111111, 7'b0000000, 6'o70, 1'b0},
        {7'b0010111, 7'b0011111, 6'o55, 1'b0},
        {7'b0111111, 7'b0101011, 6'o66, 1'b1},
        {7'b1011111, 7'b0000101, 6'o73, 1'b0},
        {7'b0001000, 7'b0001111, 6'o44, 1'b1}
    };

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [6:0] cq [16];
    logic [6:0] fq [16];
    logic [5:0] wq [16];
    logic       eq [16];
    logic [2:0] dac_fine [16];
    int s_idx, r_idx, v_idx, f_idx, both_cnt, first_valid_s;
    int t_samp, t_fine;

    always @(posedge clk) cyc <= cyc + 1;

    // Analog stand-in: present comparator patterns and record outputs.
    always @(negedge clk) begin
        if (sample_hold) begin
            coarse_therm = cq[s_idx[3:0]];
            t_samp = cyc;
            s_idx++;
        end
        if (residue_hold) begin
            fine_therm = fq[r_idx[3:0]];
            r_idx++;
        end
        if (fine_latch) begin
            t_fine = cyc;
            dac_fine[f_idx[3:0]] = dac_code;
            if (coarse_latch) both_cnt++;
            f_idx++;
        end
        if (word_valid) begin
            if (v_idx == 0) first_valid_s = s_idx;
            wq[v_idx[3:0]] = word_out;
            eq[v_idx[3:0]] = word_err;
            v_idx++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        s_idx = 0; r_idx = 0; v_idx = 0; f_idx = 0; both_cnt = 0;
        first_valid_s = -1;
    endtask

    function automatic logic [5:0] gray_word(input logic [5:0] w);
        return {w[5:3] ^ (w[5:3] >> 1), w[2:0] ^ (w[2:0] >> 1)};
    endfunction

    // Run n samples from cq/fq, then wait for n words.
    task automatic run_burst(input int n);
        @(negedge clk);
        start = 1'b1;
        while (s_idx < n) @(negedge clk);
        start = 1'b0;
        while (v_idx < n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; pipe_en = 1'b0; gray_sel = 1'b0;
        settle_cnt = 8'd2; coarse_therm = '0; fine_therm = '0;
        clear_log();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset dac", 32'(dac_code), 0);
        chk("R10 reset valid/word", 32'({word_valid, word_out}), 0);
        chk("R10 reset strobes", 32'({sample_hold, coarse_latch, residue_hold, fine_latch}), 0);
        rst_n = 1'b1;

        // Table walk, non-pipelined, binary fields (R1, R3, R4, R5, R6)
        for (int i = 0; i < 8; i++) begin
            clear_log();
            cq[0] = VEC[i][20:14];
            fq[0] = VEC[i][13:7];
            run_burst(1);
            chk((i == 4 || i == 6) ? "R5 bubble word" : "R1 word", 32'(wq[0]), 32'(VEC[i][6:1]));
            chk("R6 error flag", 32'(eq[0]), 32'(VEC[i][0]));
            chk("R4 dac at fine latch", 32'(dac_fine[0]), 32'(VEC[i][6:4]));
            chk("R3 sample to fine", 32'(t_fine - t_samp), 32'(5 + 2));
            chk("R9 one pulse", 32'(v_idx), 1);
        end

        // R3: other settle counts
        for (int s = 0; s < 8; s += 7) begin
            settle_cnt = 8'(s);
            clear_log();
            cq[0] = VEC[2][20:14]; fq[0] = VEC[2][13:7];
            run_burst(1);
            chk("R3 settle timing", 32'(t_fine - t_samp), 32'(5 + s));
            chk("R1 word after settle", 32'(wq[0]), 32'(VEC[2][6:1]));
        end
        settle_cnt = 8'd2;

        // R2: Gray-coded fields
        gray_sel = 1'b1;
        for (int i = 2; i < 8; i += 2) begin
            clear_log();
            cq[0] = VEC[i][20:14]; fq[0] = VEC[i][13:7];
            run_burst(1);
            chk("R2 gray word", 32'(wq[0]), 32'(gray_word(VEC[i][6:1])));
        end
        gray_sel = 1'b0;

        // R7/R8: pipelined burst of four distinct samples, then flush
        pipe_en = 1'b1;
        clear_log();
        cq[0] = VEC[1][20:14]; fq[0] = VEC[1][13:7];
        cq[1] = VEC[2][20:14]; fq[1] = VEC[2][13:7];
        cq[2] = VEC[3][20:14]; fq[2] = VEC[3][13:7];
        cq[3] = VEC[6][20:14]; fq[3] = VEC[6][13:7];
        run_burst(4);
        chk("R7 word 0", 32'(wq[0]), 32'(VEC[1][6:1]));
        chk("R7 word 1", 32'(wq[1]), 32'(VEC[2][6:1]));
        chk("R7 word 2", 32'(wq[2]), 32'(VEC[3][6:1]));
        chk("R8 flushed word 3", 32'(wq[3]), 32'(VEC[6][6:1]));
        chk("R7 overlapped captures", 32'(both_cnt), 3);
        chk("R7 first valid after second sample", 32'(first_valid_s >= 2), 1);
        chk("R9 words per sample", 32'(v_idx), 4);

        // R8: single pipelined sample completes by flush
        clear_log();
        cq[0] = VEC[5][20:14]; fq[0] = VEC[5][13:7];
        run_burst(1);
        chk("R8 flush single word", 32'(wq[0]), 32'(VEC[5][6:1]));
        chk("R6 flush error", 32'(eq[0]), 1);
        pipe_en = 1'b0;

        // R10: reset in the middle of a conversion
        settle_cnt = 8'd20;
        clear_log();
        cq[0] = VEC[3][20:14]; fq[0] = VEC[3][13:7];
        @(negedge clk);
        start = 1'b1;
        while (s_idx < 1) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 dac during settle", 32'(dac_code), 7);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset dac", 32'(dac_code), 0);
        chk("R10 mid reset valid", 32'(word_valid), 0);
        rst_n = 1'b1;
        settle_cnt = 8'd2;
        clear_log();
        cq[0] = VEC[4][20:14]; fq[0] = VEC[4][13:7];
        run_burst(1);
        chk("R10 recovery word", 32'(wq[0]), 32'(VEC[4][6:1]));

        summary();
    end

endmodule